// File: doc/BRIEF.md
# I2C Operating Mode Tracker

This block holds the two status bits that place an I2C controller in one of four operating modes. One bit selects master or slave, and the other selects transmit or receive. The block does not watch SCL or SDA. Other logic watches the bus, compares addresses and detects lost arbitration, and sends the results here as single-cycle pulses. From these pulses, and from the R/W# bit of the current address byte, the tracker moves between modes without help.

Software can force either bit through a write port. A write takes effect only when an override-enable bit is presented with it.

Internally, a decoder reduces each cycle's inputs to a single action, chosen by a fixed priority. A state machine applies that action to the registered mode, and an output stage splits the mode into the two bits and a two-bit code.

The state machine has four states:
- `MODE_SLV_RX` (00)
- `MODE_SLV_TX` (01)
- `MODE_MST_RX` (10)
- `MODE_MST_TX` (11)

The actions, which are the transitions, are:
- `ACT_HOLD`: keep the current state.
- `ACT_IDLE_CLR`: go to `MODE_SLV_RX`.
- `ACT_CLAIM`: go to `MODE_MST_TX`.
- `ACT_RESTART`: go to `MODE_SLV_RX` from a slave state.
- `ACT_DIR_TX`: set the direction bit to 1 and keep the role.
- `ACT_DIR_RX`: set the direction bit to 0 and keep the role.
- `ACT_SW_LOAD`: load the written pair.

Every change appears on the outputs one clock after the triggering input.

Top module: `i2c_mode_tracker`

## Requirements
- R1: When `rst_n` is low, the block enters slave-receive mode: master=0, transmit=0, mode=00.
- R2: The mode code always equals {master, transmit}. 00 is slave receive, 01 is slave transmit, 10 is master receive and 11 is master transmit.
- R3: A start detection while `start_req` is high moves the block to master transmit (11).
- R4: A stop detection or an arbitration loss moves the block to slave receive (00).
- R5: While master=1, an address-sent pulse sets transmit to the inverse of `addr_rw` and keeps master at 1. While master=0, the pulse is ignored.
- R6: While master=0, an address match sets transmit to `addr_rw`. A general call match clears transmit and wins over an ordinary match in the same cycle. While master=1, both matches are ignored.
- R7: While master=0, a start detection without `start_req` and with `bus_busy` high is a restart and clears transmit. With `bus_busy` low, the same start changes nothing.
- R8: A software write loads {wr_master, wr_transmit} only when `wr_override` is 1. With `wr_override` at 0, the write is ignored.
- R9: A `ctl_reset` pulse clears both bits.
- R10: Priority within one cycle, from highest to lowest:
  1. `ctl_reset`
  2. stop or arbitration loss
  3. start with request
  4. restart
  5. master address
  6. general call
  7. slave match
  8. software write

  A write is applied only when no higher-priority action is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_reset | input | 1 | Controller or internal reset pulse |
| start_det | input | 1 | Start condition detected |
| start_req | input | 1 | This node has a start-issue request pending |
| bus_busy | input | 1 | Bus is busy |
| stop_det | input | 1 | Stop condition detected |
| arb_lost | input | 1 | Arbitration lost |
| mst_addr_done | input | 1 | Address byte sent as master |
| slv_addr_match | input | 1 | Received address matched as slave |
| gcall_match | input | 1 | General call address matched |
| addr_rw | input | 1 | R/W# bit of the current address byte |
| wr_en | input | 1 | Software write strobe |
| wr_override | input | 1 | Write protection override enable |
| wr_master | input | 1 | Written master bit |
| wr_transmit | input | 1 | Written transmit bit |
| master | output | 1 | 1 for master, 0 for slave |
| transmit | output | 1 | 1 for transmit, 0 for receive |
| mode | output | 2 | Operating mode code {master, transmit} |

## Verification
Directed sequences walk the normal transfer paths:
- a master claim followed by a write address, then a read address;
- slave matches with both R/W# values, and a general call;
- a restart with the bus busy and with it idle.

These separate the role-keeping direction actions from the full-clearing actions. Further directed cycles put pairs of events in the same cycle, which exposes any error in the priority order. Constrained random traffic puts every event pulse into every starting mode, including writes with and without override. A bench model of the priority rules predicts the next mode. This shows whether an event is wrongly honoured in the opposite role and whether a protected write leaks through.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_SLV_RX = 2'b00,
        MODE_SLV_TX = 2'b01,
        MODE_MST_RX = 2'b10,
        MODE_MST_TX = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,
        ACT_IDLE_CLR = 3'd1,
        ACT_CLAIM    = 3'd2,
        ACT_RESTART  = 3'd3,
        ACT_DIR_TX   = 3'd4,
        ACT_DIR_RX   = 3'd5,
        ACT_SW_LOAD  = 3'd6
    } act_e;

endpackage

// File: rtl/i2c_mode_evt_decode.sv
module i2c_mode_evt_decode
    import i2c_mode_pkg::*;
(
    input  logic              cur_master,
    input  logic              ctl_reset,
    input  logic              start_det,
    input  logic              start_req,
    input  logic              bus_busy,
    input  logic              stop_det,
    input  logic              arb_lost,
    input  logic              mst_addr_done,
    input  logic              slv_addr_match,
    input  logic              gcall_match,
    input  logic              addr_rw,
    input  logic              wr_en,
    input  logic              wr_override,
    input  logic              wr_master,
    input  logic              wr_transmit,
    output act_e              act,
    output logic [MODE_W-1:0] sw_mode
);

    assign sw_mode = {wr_master, wr_transmit};

    // One action per cycle, highest priority first (R10)
    always_comb begin
        act = ACT_HOLD;
        if (ctl_reset || stop_det || arb_lost) begin
            act = ACT_IDLE_CLR;
        end else if (start_det && start_req) begin
            act = ACT_CLAIM;
        end else if (start_det && bus_busy && !cur_master) begin
            act = ACT_RESTART;
        end else if (cur_master && mst_addr_done) begin
            act = addr_rw ? ACT_DIR_RX : ACT_DIR_TX;
        end else if (!cur_master && gcall_match) begin
            act = ACT_DIR_RX;
        end else if (!cur_master && slv_addr_match) begin
            act = addr_rw ? ACT_DIR_TX : ACT_DIR_RX;
        end else if (wr_en && wr_override) begin
            act = ACT_SW_LOAD;
        end
    end

endmodule

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm
    import i2c_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  act_e              act,
    input  logic [MODE_W-1:0] sw_mode,
    output mode_e             state
);

    mode_e state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MODE_SLV_RX;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (act)
            ACT_HOLD:     state_nxt = state;
            ACT_IDLE_CLR: state_nxt = MODE_SLV_RX;
            ACT_CLAIM:    state_nxt = MODE_MST_TX;
            ACT_RESTART:  state_nxt = MODE_SLV_RX;
            ACT_DIR_TX:   state_nxt = state[1] ? MODE_MST_TX : MODE_SLV_TX;
            ACT_DIR_RX:   state_nxt = state[1] ? MODE_MST_RX : MODE_SLV_RX;
            ACT_SW_LOAD:  state_nxt = mode_e'(sw_mode);
            default:      state_nxt = state;
        endcase
    end

endmodule

// File: rtl/i2c_mode_out.sv
module i2c_mode_out
    import i2c_mode_pkg::*;
(
    input  mode_e             state,
    output logic              master,
    output logic              transmit,
    output logic [MODE_W-1:0] mode
);

    always_comb begin
        master   = 1'b0;
        transmit = 1'b0;
        unique case (state)
            MODE_SLV_RX: begin master = 1'b0; transmit = 1'b0; end
            MODE_SLV_TX: begin master = 1'b0; transmit = 1'b1; end
            MODE_MST_RX: begin master = 1'b1; transmit = 1'b0; end
            MODE_MST_TX: begin master = 1'b1; transmit = 1'b1; end
            default:     begin master = 1'b0; transmit = 1'b0; end
        endcase
        mode = state;
    end

endmodule

// File: rtl/i2c_mode_tracker.sv
module i2c_mode_tracker
    import i2c_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_reset,
    input  logic       start_det,
    input  logic       start_req,
    input  logic       bus_busy,
    input  logic       stop_det,
    input  logic       arb_lost,
    input  logic       mst_addr_done,
    input  logic       slv_addr_match,
    input  logic       gcall_match,
    input  logic       addr_rw,
    input  logic       wr_en,
    input  logic       wr_override,
    input  logic       wr_master,
    input  logic       wr_transmit,
    output logic       master,
    output logic       transmit,
    output logic [1:0] mode
);

    act_e              act;
    logic [MODE_W-1:0] sw_mode;
    mode_e             state;

    i2c_mode_evt_decode u_dec (
        .cur_master     (master),
        .ctl_reset      (ctl_reset),
        .start_det      (start_det),
        .start_req      (start_req),
        .bus_busy       (bus_busy),
        .stop_det       (stop_det),
        .arb_lost       (arb_lost),
        .mst_addr_done  (mst_addr_done),
        .slv_addr_match (slv_addr_match),
        .gcall_match    (gcall_match),
        .addr_rw        (addr_rw),
        .wr_en          (wr_en),
        .wr_override    (wr_override),
        .wr_master      (wr_master),
        .wr_transmit    (wr_transmit),
        .act            (act),
        .sw_mode        (sw_mode)
    );

    i2c_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .sw_mode (sw_mode),
        .state   (state)
    );

    i2c_mode_out u_out (
        .state    (state),
        .master   (master),
        .transmit (transmit),
        .mode     (mode)
    );

endmodule

// File: rtl/i2c_mode_tracker_chk.sv
module i2c_mode_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_reset,
    input logic       start_det,
    input logic       start_req,
    input logic       stop_det,
    input logic       arb_lost,
    input logic       mst_addr_done,
    input logic       slv_addr_match,
    input logic       gcall_match,
    input logic       addr_rw,
    input logic       wr_en,
    input logic       wr_override,
    input logic       master,
    input logic       transmit,
    input logic [1:0] mode
);

    logic clear_evt;
    logic quiet;
    assign clear_evt = ctl_reset || stop_det || arb_lost;
    assign quiet = !clear_evt && !start_det && !mst_addr_done && !slv_addr_match
                   && !gcall_match && !(wr_en && wr_override);

    a_r2_code_matches_bits: assert property (@(posedge clk) disable iff (!rst_n)
        mode == {master, transmit});

    a_r9_ctl_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_reset |=> (!master && !transmit));

    a_r4_stop_or_al_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || arb_lost) |=> (mode == 2'b00));

    a_r3_claim_master_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_evt && start_det && start_req) |=> (mode == 2'b11));

    a_r5_master_addr_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_evt && !start_det && master && mst_addr_done)
        |=> (master && (transmit != $past(addr_rw))));

    a_r8_no_change_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(mode));

endmodule

bind i2c_mode_tracker i2c_mode_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_reset      (ctl_reset),
    .start_det      (start_det),
    .start_req      (start_req),
    .stop_det       (stop_det),
    .arb_lost       (arb_lost),
    .mst_addr_done  (mst_addr_done),
    .slv_addr_match (slv_addr_match),
    .gcall_match    (gcall_match),
    .addr_rw        (addr_rw),
    .wr_en          (wr_en),
    .wr_override    (wr_override),
    .master         (master),
    .transmit       (transmit),
    .mode           (mode)
);

// File: tb/test_i2c_mode_tracker.sv
`timescale 1ns/1ps
module test_i2c_mode_tracker;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_reset, start_det, start_req, bus_busy, stop_det, arb_lost;
    logic       mst_addr_done, slv_addr_match, gcall_match, addr_rw;
    logic       wr_en, wr_override, wr_master, wr_transmit;
    logic       master, transmit;
    logic [1:0] mode;

    int n_vec  = 0;
    int n_fail = 0;
    logic [1:0] exp_mode;

    always #4 clk = ~clk;

    i2c_mode_tracker i_i2c_mode_tracker (
        .clk(clk), .rst_n(rst_n), .ctl_reset(ctl_reset), .start_det(start_det),
        .start_req(start_req), .bus_busy(bus_busy), .stop_det(stop_det),
        .arb_lost(arb_lost), .mst_addr_done(mst_addr_done),
        .slv_addr_match(slv_addr_match), .gcall_match(gcall_match),
        .addr_rw(addr_rw), .wr_en(wr_en), .wr_override(wr_override),
        .wr_master(wr_master), .wr_transmit(wr_transmit),
        .master(master), .transmit(transmit), .mode(mode)
    );

    // Reference model of the priority rules
    function automatic logic [1:0] model_next(input logic [1:0] cur);
        logic m;
        m = cur[1];
        if (ctl_reset)                               return 2'b00;
        if (stop_det || arb_lost)                    return 2'b00;
        if (start_det && start_req)                  return 2'b11;
        if (start_det && bus_busy && !m)             return 2'b00;
        if (m && mst_addr_done)                      return {1'b1, !addr_rw};
        if (!m && gcall_match)                       return 2'b00;
        if (!m && slv_addr_match)                    return {1'b0, addr_rw};
        if (wr_en && wr_override)                    return {wr_master, wr_transmit};
        return cur;
    endfunction

    function automatic string model_tag(input logic [1:0] cur);
        logic m;
        m = cur[1];
        if (ctl_reset)                   return "R9";
        if (stop_det || arb_lost)        return "R4";
        if (start_det && start_req)      return "R3";
        if (start_det && bus_busy && !m) return "R7";
        if (m && mst_addr_done)          return "R5";
        if (!m && (gcall_match || slv_addr_match)) return "R6";
        if (wr_en)                       return "R8";
        return "R10";
    endfunction

    task automatic idle_inputs();
        ctl_reset = 0; start_det = 0; start_req = 0; bus_busy = 0; stop_det = 0;
        arb_lost = 0; mst_addr_done = 0; slv_addr_match = 0; gcall_match = 0;
        addr_rw = 0; wr_en = 0; wr_override = 0; wr_master = 0; wr_transmit = 0;
    endtask

    // Inputs are already set; advance one clock and compare at the falling edge
    task automatic step();
        string tag;
        tag = model_tag(exp_mode);
        exp_mode = model_next(exp_mode);
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (mode !== exp_mode || master !== exp_mode[1] || transmit !== exp_mode[0]) begin
            n_fail++;
            $display("FAIL %s: mode=%b master=%b transmit=%b expected mode=%b",
                     tag, mode, master, transmit, exp_mode);
        end
        idle_inputs();
    endtask

    task automatic sw_write(input logic ov, input logic m, input logic t);
        wr_en = 1; wr_override = ov; wr_master = m; wr_transmit = t;
        step();
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C2D_5A11));
        idle_inputs();
        rst_n = 0;
        exp_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_vec++;
        if (mode !== 2'b00 || master !== 1'b0 || transmit !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: mode=%b expected=00", mode);
        end

        // R3, R5: claim, write address, then read address
        start_det = 1; start_req = 1; step();
        mst_addr_done = 1; addr_rw = 0; step();
        mst_addr_done = 1; addr_rw = 1; step();
        // R6: slave match ignored while master
        slv_addr_match = 1; addr_rw = 1; step();
        // R4: stop clears
        stop_det = 1; step();
        // R5: master address ignored in slave
        mst_addr_done = 1; addr_rw = 0; step();
        // R6: slave read match, then general call beats read match
        slv_addr_match = 1; addr_rw = 1; step();
        gcall_match = 1; slv_addr_match = 1; addr_rw = 1; step();
        slv_addr_match = 1; addr_rw = 1; step();
        // R7: start without request, bus idle -> nothing; bus busy -> restart
        start_det = 1; bus_busy = 0; step();
        start_det = 1; bus_busy = 1; step();
        // R8: protected write ignored, override write applied
        sw_write(0, 1, 1);
        sw_write(1, 1, 0);
        // R4: arbitration loss clears master
        arb_lost = 1; step();
        // R10: collisions
        sw_write(1, 1, 1);
        ctl_reset = 1; start_det = 1; start_req = 1; step();
        start_det = 1; start_req = 1; stop_det = 1; step();
        start_det = 1; start_req = 1; wr_en = 1; wr_override = 1; step();
        ctl_reset = 1; step();
        // R9: reset from master transmit
        start_det = 1; start_req = 1; step();
        ctl_reset = 1; step();

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            ctl_reset      = ($urandom_range(0, 39) == 0);
            stop_det       = ($urandom_range(0, 11) == 0);
            arb_lost       = ($urandom_range(0, 15) == 0);
            start_det      = ($urandom_range(0, 5) == 0);
            start_req      = ($urandom_range(0, 1) == 0);
            bus_busy       = ($urandom_range(0, 1) == 0);
            mst_addr_done  = ($urandom_range(0, 4) == 0);
            slv_addr_match = ($urandom_range(0, 4) == 0);
            gcall_match    = ($urandom_range(0, 9) == 0);
            addr_rw        = ($urandom_range(0, 1) == 0);
            wr_en          = ($urandom_range(0, 3) == 0);
            wr_override    = ($urandom_range(0, 1) == 0);
            wr_master      = ($urandom_range(0, 1) == 0);
            wr_transmit    = ($urandom_range(0, 1) == 0);
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule